// File: doc/BRIEF.md
# Private/Shared NUCA Request Sequencer

This block steers one core's last-level cache requests across a non-uniform cache of 2^n banks that serves 2^p cores. Every core owns a group of 2^(n-p) nearby banks for lines only it uses. Every line also has one shared home bank that depends only on its address. A request is first looked up in the requester's own private group. On a miss it goes to the line's shared home. If that misses too, the other cores' private banks and memory are queried together.

The sequencer takes one request at a time. It decodes the line address into private and shared bank, set and tag fields. It issues probe commands and collects hit/miss replies. It ends the request with a single done pulse that names where the line was found. A line found in another core's private bank is moved to its shared home as a shared line. A line that only memory supplies is installed as private in the requester's own group. A line found in its shared home is left where it is, so it stays shared.

Top module: `nuca_req_seq`

## Requirements
- R1: A private lookup (probeShared=0) addresses bank {reqCore, addr[B+n-p-1:B]}, set addr[B+n-p+i-1:B+n-p] and tag addr[top:B+n-p+i]. B is the byte-offset width, i the set width and top the most significant address bit.
- R2: A shared lookup (probeShared=1) addresses bank addr[B+n-1:B], set addr[B+n+i-1:B+n] and tag addr[top:B+n+i], zero-extended at the top to the private tag width.
- R3: The cycle after a request is accepted, the block issues exactly one private probe.
- R4: A private hit ends the request with doneSrc=0 and no further probe, broadcast, migrate or fill.
- R5: A private miss is followed in the next cycle by a shared probe. A shared hit ends the request with doneSrc=1 and no migrate or fill, so the line stays shared.
- R6: A shared miss is followed in the next cycle by one cycle with both bcastValid and memReqValid high. bcastMask then has one bit per core, with every core's bit set except the requester's, and bcastSlot=addr[B+n-p-1:B].
- R7: A remote private hit gives doneSrc=2 with migValid. The migrate targets the shared home bank, set and tag, with migSrcBank={remRspCore, addr[B+n-p-1:B]}. The memory reply is discarded whether it came earlier or later.
- R8: A remote miss together with a memory reply gives doneSrc=3 with fillValid. The fill targets the requester's private bank, set and tag.
- R9: After a broadcast the block finishes only after both the remote reply and the memory reply have arrived, in either order. doneValid rises one cycle after the later of the two is sampled.
- R10: reqReady is high only while idle. A request presented while busy is dropped and does not change the request in flight.
- R11: doneValid is a one-cycle pulse. Any migrate or fill command comes in the same cycle, and the block is ready again in the following cycle.
- R12: After reset the block is idle with reqReady high and no probe, broadcast, command or done output active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New request |
| reqAddr | input | ADDR_W | Request byte address |
| reqCore | input | CORE_P | Requesting core |
| reqReady | output | 1 | Idle and able to accept |
| probeValid | output | 1 | Bank probe command |
| probeShared | output | 1 | Probe is a shared lookup |
| probeBank | output | BANK_N | Probed bank |
| probeSet | output | SET_I | Probed set; private set during a broadcast |
| probeTag | output | TAG_W | Probed tag; private tag during a broadcast |
| rspValid | input | 1 | Probe reply |
| rspHit | input | 1 | Probe reply hit |
| bcastValid | output | 1 | Broadcast to other private groups |
| bcastMask | output | 2^CORE_P | Cores addressed by the broadcast |
| bcastSlot | output | BANK_N-CORE_P | Bank slot inside each private group |
| memReqValid | output | 1 | Memory read request |
| remRspValid | input | 1 | Combined remote reply |
| remRspHit | input | 1 | A remote private bank holds the line |
| remRspCore | input | CORE_P | Core whose group holds it |
| memRspValid | input | 1 | Memory reply |
| migValid | output | 1 | Migrate line to shared home |
| fillValid | output | 1 | Install line as private |
| cmdBank | output | BANK_N | Target bank of migrate or fill |
| cmdSet | output | SET_I | Target set |
| cmdTag | output | TAG_W | Target tag |
| migSrcBank | output | BANK_N | Remote bank the migrated line leaves |
| doneValid | output | 1 | Request complete |
| doneSrc | output | 2 | 0 private, 1 shared, 2 remote, 3 memory |

## Verification
Each result has a fixed distance in cycles from the stimulus that causes it. The private probe appears one cycle after acceptance. The shared probe and the broadcast each appear one cycle after the reply that missed. doneValid appears one cycle after the deciding reply, and reqReady returns one cycle later. The bench drives inputs and samples outputs on falling edges. Each check is placed on the exact falling edge where that count of registers puts the result. The bench varies the remote and memory reply delays so that memory replies first, remote replies first, or both reply together.

// File: rtl/nuca_seq_pkg.sv
package nuca_seq_pkg;

  typedef enum logic [1:0] {
    SRC_PRIV   = 2'd0,
    SRC_SHARED = 2'd1,
    SRC_REMOTE = 2'd2,
    SRC_MEMORY = 2'd3
  } hitSrcE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIV_ISSUE,
    ST_PRIV_WAIT,
    ST_SH_ISSUE,
    ST_SH_WAIT,
    ST_BC_ISSUE,
    ST_BC_WAIT,
    ST_DONE
  } seqStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch a new request
    logic useShared;   // drive shared-view fields on the probe bus
    logic clearFlags;  // forget previous broadcast replies
    logic collect;     // accept remote/memory replies
  } dpStrobeT;

endpackage

// File: rtl/nuca_seq_datapath.sv
module nuca_seq_datapath
  import nuca_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTE_B = 6,
  parameter int BANK_N = 5,
  parameter int CORE_P = 3,
  parameter int SET_I  = 8,
  localparam int PRIV_W    = BANK_N - CORE_P,
  localparam int CORES     = 1 << CORE_P,
  localparam int TAG_W     = ADDR_W - BYTE_B - PRIV_W - SET_I,
  localparam int SH_TAG_W  = TAG_W - CORE_P
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobeT             strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [CORE_P-1:0]    reqCore,
  input  logic                 remRspValid,
  input  logic                 remRspHit,
  input  logic [CORE_P-1:0]    remRspCore,
  input  logic                 memRspValid,
  output logic [BANK_N-1:0]    probeBank,
  output logic [SET_I-1:0]     probeSet,
  output logic [TAG_W-1:0]     probeTag,
  output logic [CORES-1:0]     bcastMask,
  output logic [PRIV_W-1:0]    bcastSlot,
  output logic [BANK_N-1:0]    cmdBank,
  output logic [SET_I-1:0]     cmdSet,
  output logic [TAG_W-1:0]     cmdTag,
  output logic [BANK_N-1:0]    migSrcBank,
  output logic                 remKnown,
  output logic                 memKnown,
  output logic                 hitKnown
);

  logic [ADDR_W-1:BYTE_B] lineReg;
  logic [CORE_P-1:0]      coreReg;
  logic [CORE_P-1:0]      remCoreReg;
  logic                   remSeen, memSeen, remHitFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineReg <= '0;
      coreReg <= '0;
    end else if (strobe.capture) begin
      lineReg <= reqAddr[ADDR_W-1:BYTE_B];
      coreReg <= reqCore;
    end
  end

  // address views
  logic [PRIV_W-1:0]  privSel;
  logic [BANK_N-1:0]  privBank, shBank;
  logic [SET_I-1:0]   privSet, shSet;
  logic [TAG_W-1:0]   privTag, shTag;

  always_comb begin
    privSel  = lineReg[BYTE_B +: PRIV_W];
    privBank = {coreReg, privSel};
    shBank   = lineReg[BYTE_B +: BANK_N];
    privSet  = lineReg[BYTE_B + PRIV_W +: SET_I];
    shSet    = lineReg[BYTE_B + BANK_N +: SET_I];
    privTag  = lineReg[ADDR_W-1 -: TAG_W];
    shTag    = {{CORE_P{1'b0}}, lineReg[ADDR_W-1 -: SH_TAG_W]};
  end

  assign probeBank = strobe.useShared ? shBank : privBank;
  assign probeSet  = strobe.useShared ? shSet  : privSet;
  assign probeTag  = strobe.useShared ? shTag  : privTag;
  assign bcastSlot = privSel;

  for (genvar c = 0; c < CORES; c++) begin : g_mask
    assign bcastMask[c] = (coreReg != CORE_P'(c));
  end

  // broadcast reply collection
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearFlags) begin
      remSeen    <= 1'b0;
      memSeen    <= 1'b0;
      remHitFlag <= 1'b0;
      remCoreReg <= '0;
    end else if (strobe.collect) begin
      if (remRspValid) begin
        remSeen    <= 1'b1;
        remHitFlag <= remRspHit;
        if (remRspHit) remCoreReg <= remRspCore;
      end
      if (memRspValid) memSeen <= 1'b1;
    end
  end

  assign remKnown = remSeen | (strobe.collect & remRspValid);
  assign memKnown = memSeen | (strobe.collect & memRspValid);
  assign hitKnown = remHitFlag | (strobe.collect & remRspValid & remRspHit);

  // remote hit moves to shared home, memory fill stays private
  assign cmdBank    = remHitFlag ? shBank : privBank;
  assign cmdSet     = remHitFlag ? shSet  : privSet;
  assign cmdTag     = remHitFlag ? shTag  : privTag;
  assign migSrcBank = {remCoreReg, privSel};

  // collected replies are held until the next broadcast
  assert_hold_mem_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memSeen && !strobe.clearFlags) |=> memSeen);
  assert_hold_rem_R9: assert property (@(posedge clk) disable iff (!rstN)
    (remSeen && !strobe.clearFlags) |=> (remSeen && $stable(remHitFlag)));

endmodule

// File: rtl/nuca_seq_control.sv
module nuca_seq_control
  import nuca_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      rspValid,
  input  logic      rspHit,
  input  logic      remKnown,
  input  logic      memKnown,
  input  logic      hitKnown,
  output dpStrobeT  strobe,
  output logic      reqReady,
  output logic      probeValid,
  output logic      probeShared,
  output logic      bcastValid,
  output logic      memReqValid,
  output logic      migValid,
  output logic      fillValid,
  output logic      doneValid,
  output logic [1:0] doneSrc
);

  seqStateE state, stateNext;
  hitSrcE   srcReg, srcNext;

  always_comb begin
    stateNext = state;
    srcNext   = srcReg;
    unique case (state)
      ST_IDLE:       if (reqValid) stateNext = ST_PRIV_ISSUE;
      ST_PRIV_ISSUE: stateNext = ST_PRIV_WAIT;
      ST_PRIV_WAIT:
        if (rspValid) begin
          if (rspHit) begin stateNext = ST_DONE; srcNext = SRC_PRIV; end
          else stateNext = ST_SH_ISSUE;
        end
      ST_SH_ISSUE:   stateNext = ST_SH_WAIT;
      ST_SH_WAIT:
        if (rspValid) begin
          if (rspHit) begin stateNext = ST_DONE; srcNext = SRC_SHARED; end
          else stateNext = ST_BC_ISSUE;
        end
      ST_BC_ISSUE:   stateNext = ST_BC_WAIT;
      ST_BC_WAIT:
        if (remKnown && memKnown) begin
          stateNext = ST_DONE;
          srcNext   = hitKnown ? SRC_REMOTE : SRC_MEMORY;
        end
      ST_DONE:       stateNext = ST_IDLE;
      default:       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      srcReg <= SRC_PRIV;
    end else begin
      state  <= stateNext;
      srcReg <= srcNext;
    end
  end

  always_comb begin
    strobe.capture    = (state == ST_IDLE) && reqValid;
    strobe.useShared  = (state == ST_SH_ISSUE) || (state == ST_SH_WAIT)
                        || ((state == ST_DONE) && (srcReg == SRC_SHARED));
    strobe.clearFlags = (state == ST_BC_ISSUE);
    strobe.collect    = (state == ST_BC_WAIT);
  end

  assign reqReady    = (state == ST_IDLE);
  assign probeValid  = (state == ST_PRIV_ISSUE) || (state == ST_SH_ISSUE);
  assign probeShared = (state == ST_SH_ISSUE);
  assign bcastValid  = (state == ST_BC_ISSUE);
  assign memReqValid = (state == ST_BC_ISSUE);
  assign doneValid   = (state == ST_DONE);
  assign migValid    = doneValid && (srcReg == SRC_REMOTE);
  assign fillValid   = doneValid && (srcReg == SRC_MEMORY);
  assign doneSrc     = srcReg;

  assert_private_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (probeValid && !probeShared));
  assert_shared_next_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PRIV_WAIT) && rspValid && !rspHit) |=> (probeValid && probeShared));
  assert_bcast_with_mem_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SH_WAIT) && rspValid && !rspHit) |=> (bcastValid && memReqValid));
  assert_wait_both_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_BC_WAIT) && !(remKnown && memKnown)) |=> !doneValid);
  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(probeValid || bcastValid || doneValid));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));
  assert_one_cmd_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({probeValid, bcastValid, migValid, fillValid}));

endmodule

// File: rtl/nuca_req_seq.sv
module nuca_req_seq
  import nuca_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTE_B = 6,
  parameter int BANK_N = 5,
  parameter int CORE_P = 3,
  parameter int SET_I  = 8,
  localparam int PRIV_W = BANK_N - CORE_P,
  localparam int CORES  = 1 << CORE_P,
  localparam int TAG_W  = ADDR_W - BYTE_B - PRIV_W - SET_I
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [CORE_P-1:0]  reqCore,
  output logic               reqReady,
  output logic               probeValid,
  output logic               probeShared,
  output logic [BANK_N-1:0]  probeBank,
  output logic [SET_I-1:0]   probeSet,
  output logic [TAG_W-1:0]   probeTag,
  input  logic               rspValid,
  input  logic               rspHit,
  output logic               bcastValid,
  output logic [CORES-1:0]   bcastMask,
  output logic [PRIV_W-1:0]  bcastSlot,
  output logic               memReqValid,
  input  logic               remRspValid,
  input  logic               remRspHit,
  input  logic [CORE_P-1:0]  remRspCore,
  input  logic               memRspValid,
  output logic               migValid,
  output logic               fillValid,
  output logic [BANK_N-1:0]  cmdBank,
  output logic [SET_I-1:0]   cmdSet,
  output logic [TAG_W-1:0]   cmdTag,
  output logic [BANK_N-1:0]  migSrcBank,
  output logic               doneValid,
  output logic [1:0]         doneSrc
);

  dpStrobeT strobe;
  logic remKnown, memKnown, hitKnown;

  nuca_seq_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .rspValid(rspValid), .rspHit(rspHit),
    .remKnown(remKnown), .memKnown(memKnown), .hitKnown(hitKnown),
    .strobe(strobe), .reqReady(reqReady),
    .probeValid(probeValid), .probeShared(probeShared),
    .bcastValid(bcastValid), .memReqValid(memReqValid),
    .migValid(migValid), .fillValid(fillValid),
    .doneValid(doneValid), .doneSrc(doneSrc)
  );

  nuca_seq_datapath #(
    .ADDR_W(ADDR_W), .BYTE_B(BYTE_B), .BANK_N(BANK_N),
    .CORE_P(CORE_P), .SET_I(SET_I)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqCore(reqCore),
    .remRspValid(remRspValid), .remRspHit(remRspHit),
    .remRspCore(remRspCore), .memRspValid(memRspValid),
    .probeBank(probeBank), .probeSet(probeSet), .probeTag(probeTag),
    .bcastMask(bcastMask), .bcastSlot(bcastSlot),
    .cmdBank(cmdBank), .cmdSet(cmdSet), .cmdTag(cmdTag),
    .migSrcBank(migSrcBank),
    .remKnown(remKnown), .memKnown(memKnown), .hitKnown(hitKnown)
  );

  assert_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    bcastValid |-> ($countones(bcastMask) == CORES - 1));
  assert_migrate_R7: assert property (@(posedge clk) disable iff (!rstN)
    migValid |-> (doneValid && doneSrc == 2'd2));
  assert_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> (doneValid && doneSrc == 2'd3));

endmodule

// File: tb/sim_nuca_req_seq.sv
module sim_nuca_req_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        reqValid = 0, rspValid = 0, rspHit = 0;
  logic        remRspValid = 0, remRspHit = 0, memRspValid = 0;
  logic [31:0] reqAddr = 0;
  logic [2:0]  reqCore = 0, remRspCore = 0;
  logic        reqReady, probeValid, probeShared, bcastValid, memReqValid;
  logic        migValid, fillValid, doneValid;
  logic [4:0]  probeBank, cmdBank, migSrcBank;
  logic [7:0]  probeSet, cmdSet, bcastMask;
  logic [15:0] probeTag, cmdTag;
  logic [1:0]  bcastSlot, doneSrc;

  nuca_req_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCore(reqCore), .reqReady(reqReady), .probeValid(probeValid),
    .probeShared(probeShared), .probeBank(probeBank), .probeSet(probeSet),
    .probeTag(probeTag), .rspValid(rspValid), .rspHit(rspHit),
    .bcastValid(bcastValid), .bcastMask(bcastMask), .bcastSlot(bcastSlot),
    .memReqValid(memReqValid), .remRspValid(remRspValid), .remRspHit(remRspHit),
    .remRspCore(remRspCore), .memRspValid(memRspValid), .migValid(migValid),
    .fillValid(fillValid), .cmdBank(cmdBank), .cmdSet(cmdSet), .cmdTag(cmdTag),
    .migSrcBank(migSrcBank), .doneValid(doneValid), .doneSrc(doneSrc)
  );

  int nChecks = 0, nFail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected fields for 6 byte bits, 32 banks, 8 cores, 256 sets
  function automatic logic [4:0]  pBank(input logic [31:0] a, input logic [2:0] c); return {c, a[7:6]}; endfunction
  function automatic logic [7:0]  pSet (input logic [31:0] a); return a[15:8]; endfunction
  function automatic logic [15:0] pTag (input logic [31:0] a); return a[31:16]; endfunction
  function automatic logic [4:0]  sBank(input logic [31:0] a); return a[10:6]; endfunction
  function automatic logic [7:0]  sSet (input logic [31:0] a); return a[18:11]; endfunction
  function automatic logic [15:0] sTag (input logic [31:0] a); return {3'b000, a[31:19]}; endfunction

  // addr | core | privHit | shHit | remHit | remCore | remDelay | memDelay | expSrc
  localparam int VW = 47;
  localparam logic [VW-1:0] VECS [0:7] = '{
    {32'h1234_5678, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 2'd1, 2'd1, 2'd0},
    {32'hDEAD_BEC0, 3'd5, 1'b0, 1'b1, 1'b0, 3'd0, 2'd1, 2'd1, 2'd1},
    {32'h0F0F_0F40, 3'd7, 1'b0, 1'b0, 1'b1, 3'd2, 2'd1, 2'd1, 2'd2},
    {32'hABCD_0080, 3'd3, 1'b0, 1'b0, 1'b1, 3'd6, 2'd3, 2'd1, 2'd2},
    {32'h5555_AAC0, 3'd1, 1'b0, 1'b0, 1'b1, 3'd0, 2'd1, 2'd3, 2'd2},
    {32'h8000_0040, 3'd4, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 2'd2, 2'd3},
    {32'hFFFF_FFC0, 3'd2, 1'b0, 1'b0, 1'b0, 3'd0, 2'd2, 2'd1, 2'd3},
    {32'h0000_0000, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 2'd1, 2'd3}
  };

  task automatic runVec(input logic [VW-1:0] v, input bit poke);
    logic [31:0] a  = v[46:15];
    logic [2:0]  c  = v[14:12];
    logic ph = v[11], sh = v[10], rh = v[9];
    logic [2:0]  rc = v[8:6];
    int rd = int'(v[5:4]), md = int'(v[3:2]);
    logic [1:0]  es = v[1:0];
    int mx = (rd > md) ? rd : md;

    @(negedge clk);
    chk(reqReady, "R10", "ready before request", reqReady, 1);
    reqValid = 1; reqAddr = a; reqCore = c;
    @(negedge clk);
    reqValid = 0;
    chk(probeValid && !probeShared, "R3", "private probe issued", {probeValid, probeShared}, 2'b10);
    chk(probeBank == pBank(a, c), "R1", "private bank", probeBank, pBank(a, c));
    chk(probeSet == pSet(a) && probeTag == pTag(a), "R1", "private set/tag",
        {probeSet, probeTag}, {pSet(a), pTag(a)});
    @(negedge clk);
    rspValid = 1; rspHit = ph;
    if (poke) begin
      chk(!reqReady, "R10", "busy not ready", reqReady, 0);
      reqValid = 1; reqAddr = ~a; reqCore = c + 3'd1;
    end
    @(negedge clk);
    rspValid = 0; reqValid = 0;
    if (ph) begin
      chk(doneValid && doneSrc == 2'd0, "R4", "private hit done", {doneValid, doneSrc}, {1'b1, 2'd0});
      chk(!migValid && !fillValid && !probeValid && !bcastValid, "R4", "no extra cmd",
          {migValid, fillValid, probeValid, bcastValid}, 0);
    end else begin
      chk(probeValid && probeShared, "R5", "shared probe after miss", {probeValid, probeShared}, 2'b11);
      chk(probeBank == sBank(a), "R2", "shared bank", probeBank, sBank(a));
      chk(probeSet == sSet(a) && probeTag == sTag(a), "R2", "shared set/tag",
          {probeSet, probeTag}, {sSet(a), sTag(a)});
      @(negedge clk);
      rspValid = 1; rspHit = sh;
      @(negedge clk);
      rspValid = 0;
      if (sh) begin
        chk(doneValid && doneSrc == 2'd1, "R5", "shared hit done", {doneValid, doneSrc}, {1'b1, 2'd1});
        chk(!migValid && !fillValid, "R5", "shared line left in place", {migValid, fillValid}, 0);
      end else begin
        chk(bcastValid && memReqValid, "R6", "broadcast with memory", {bcastValid, memReqValid}, 2'b11);
        chk(bcastMask == ~(8'd1 << c), "R6", "broadcast mask", bcastMask, ~(8'd1 << c));
        chk(bcastSlot == a[7:6], "R6", "broadcast slot", bcastSlot, a[7:6]);
        for (int k = 1; k <= mx; k++) begin
          @(negedge clk);
          if (k > 1) chk(!doneValid, "R9", "waits for both replies", doneValid, 0);
          remRspValid = (k == rd); remRspHit = (k == rd) && rh; remRspCore = rc;
          memRspValid = (k == md);
        end
        @(negedge clk);
        remRspValid = 0; remRspHit = 0; memRspValid = 0;
        chk(doneValid && doneSrc == es, "R9", "done after later reply", {doneValid, doneSrc}, {1'b1, es});
        if (rh) begin
          chk(migValid && !fillValid, "R7", "migrate not fill", {migValid, fillValid}, 2'b10);
          chk(cmdBank == sBank(a) && cmdSet == sSet(a) && cmdTag == sTag(a), "R7",
              "migrate target", {cmdBank, cmdSet, cmdTag}, {sBank(a), sSet(a), sTag(a)});
          chk(migSrcBank == {rc, a[7:6]}, "R7", "migrate source", migSrcBank, {rc, a[7:6]});
        end else begin
          chk(fillValid && !migValid, "R8", "fill not migrate", {migValid, fillValid}, 2'b01);
          chk(cmdBank == pBank(a, c) && cmdSet == pSet(a) && cmdTag == pTag(a), "R8",
              "fill target", {cmdBank, cmdSet, cmdTag}, {pBank(a, c), pSet(a), pTag(a)});
        end
      end
    end
    @(negedge clk);
    chk(!doneValid && reqReady, "R11", "done is one pulse", {doneValid, reqReady}, 2'b01);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    nFail++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady && !probeValid && !bcastValid && !memReqValid && !migValid && !fillValid && !doneValid,
        "R12", "reset state",
        {reqReady, probeValid, bcastValid, memReqValid, migValid, fillValid, doneValid}, 7'b1000000);

    for (int i = 0; i < 8; i++) runVec(VECS[i], 1'b0);

    // request while busy must not disturb the one in flight
    runVec(VECS[1], 1'b1);
    runVec(VECS[5], 1'b1);
    // replies arriving while idle start nothing
    @(negedge clk);
    memRspValid = 1; remRspValid = 1; rspValid = 1;
    @(negedge clk);
    memRspValid = 0; remRspValid = 0; rspValid = 0;
    chk(reqReady && !doneValid && !probeValid, "R10", "idle ignores replies",
        {reqReady, doneValid, probeValid}, 3'b100);
    runVec(VECS[7], 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule